// File: doc/BRIEF.md
# DMA Page Translation Walker

This block turns a 32-bit address issued by a DMA-capable device into a physical memory address. It uses a single-level linear page table that lives in system memory. Software programs two registers through a small write port. One register holds the byte address where the table starts. The other holds the table length in bytes. Pages are 4 KiB, and each table slot is 8 bytes wide: a frame word followed by an owner word. The walker reads only the frame word.

For each request the walker splits the address into a page index and a page offset. It checks the index against the programmed length. If the index is in range, it reads the table slot through a simple memory read port that uses a request pulse and a valid response. It then returns the physical address with a read/write grant. If the index is out of range, or if the memory reports an error on the slot read, it returns a no-access result instead.

Only one translation is in flight at a time. The request side sees `req_ready` low from the moment a request is taken until its response has been delivered.

Top module: `dxw_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid`, `rsp_fault` and `mem_req` are 0, and the table base and table length are both 0, so the first translation faults.
- R2: A write with `cfg_we`=1 stores `cfg_wdata` into the table base when `cfg_sel`=0 and into the table length when `cfg_sel`=1. It applies to every request accepted after that clock edge.
- R3: The page index is `req_addr[31:12]`. A request is in range only when index < floor(length / 8). An out-of-range request makes no memory read and responds in the cycle after acceptance with `rsp_fault`=1, `rsp_perm`=2'b00 and `rsp_paddr`=0.
- R4: For an in-range request, `mem_req` is high for exactly one cycle, in the cycle after acceptance. `mem_addr` equals (base with bit 31 forced to 0) + index*8.
- R5: From acceptance until the cycle after the response, `req_ready` is 0 and no further request is accepted.
- R6: When the slot read returns with `mem_rerr`=0, the next cycle carries `rsp_valid`=1, `rsp_fault`=0, `rsp_perm`=2'b11 (read and write allowed) and `rsp_paddr` = {`mem_rdata[31:12]`, `req_addr[11:0]`}.
- R7: When the slot read returns with `mem_rerr`=1, the response has `rsp_fault`=1, `rsp_perm`=2'b00 and `rsp_paddr`=0.
- R8: `rsp_valid` is a single-cycle pulse for each accepted request, and `rsp_fault` is only ever high together with `rsp_valid`.
- R9: A `mem_rvalid` pulse that arrives while no slot read is outstanding produces no response.

Ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 = table base, 1 = table length |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can take a request |
| req_addr | input | 32 | Device-side DMA address |
| mem_req | output | 1 | One-cycle slot read request |
| mem_addr | output | 32 | Byte address of the table slot |
| mem_rvalid | input | 1 | Slot read data returned |
| mem_rdata | input | 32 | Frame word of the slot |
| mem_rerr | input | 1 | Slot read failed |
| rsp_valid | output | 1 | Translation result pulse |
| rsp_paddr | output | 32 | Physical address (0 on a fault) |
| rsp_perm | output | 2 | 2'b11 read/write, 2'b00 no access |
| rsp_fault | output | 1 | Translation failed |

## Verification
The bench targets the following corner cases, each paired with the failure it would expose:

- **Length check at the last slot.** The bench probes indices 7 and 8 with a length of 64, and again with 71. A strict-versus-inclusive compare error, or a missing divide by 8, would let index 8 through and start a memory read.
- **Bit 31 of the base.** The bench sets bit 31 of the base. A walker that keeps it would put bit 31 into the slot address.
- **Frame-word low bits.** The frame word carries nonzero low bits. A walker that fails to replace them with the request offset would give a wrong physical address.
- **Read errors.** The bench injects a read error. A design that ignores `mem_rerr` would grant access with a stale frame.
- **Stray returns.** The bench sends stray `mem_rvalid` pulses while idle. A walker that responds to any return would emit spurious results.
- **Busy window.** The bench watches `req_ready` across a slow memory. A design that reopens `req_ready` early would accept overlapping requests.

// File: rtl/dxw_pkg.sv
package dxw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } walk_state_e;

  localparam logic [1:0] PERM_NONE = 2'b00;
  localparam logic [1:0] PERM_RW   = 2'b11;
endpackage

// File: rtl/dxw_cfg_regs.sv
module dxw_cfg_regs #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] limit_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      limit_q <= '0;
    end else if (cfg_we) begin
      if (cfg_sel) limit_q <= cfg_wdata;
      else         base_q  <= cfg_wdata;
    end
  end
endmodule

// File: rtl/dxw_index_check.sv
module dxw_index_check #(
  parameter int ADDR_W      = 32,
  parameter int PAGE_SHIFT  = 12,
  parameter int ENTRY_SHIFT = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  output logic              in_range,
  output logic [ADDR_W-1:0] slot_addr
);
  localparam int IDX_W = ADDR_W - PAGE_SHIFT;

  logic [IDX_W-1:0]  page_idx;
  logic [ADDR_W-1:0] idx_wide;
  logic [ADDR_W-1:0] slot_count;
  logic [ADDR_W-1:0] base_clr;

  always_comb begin
    page_idx   = addr[ADDR_W-1:PAGE_SHIFT];
    idx_wide   = ADDR_W'(page_idx);
    slot_count = limit >> ENTRY_SHIFT;
    in_range   = idx_wide < slot_count;
    base_clr   = base;
    base_clr[ADDR_W-1] = 1'b0;
    slot_addr  = base_clr + (idx_wide << ENTRY_SHIFT);
  end
endmodule

// File: rtl/dxw_seq.sv
module dxw_seq
  import dxw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              in_range,
  input  logic [ADDR_W-1:0] slot_addr,
  output logic              req_ready,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [ADDR_W-1:0] mem_rdata,
  input  logic              mem_rerr,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [1:0]        rsp_perm,
  output logic              rsp_fault
);
  walk_state_e           state_q;
  logic [PAGE_SHIFT-1:0] offset_q;

  assign req_ready = (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      offset_q  <= '0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_perm  <= PERM_NONE;
      rsp_fault <= 1'b0;
    end else begin
      mem_req   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            offset_q <= req_addr[PAGE_SHIFT-1:0];
            if (in_range) begin
              mem_req  <= 1'b1;
              mem_addr <= slot_addr;
              state_q  <= ST_WAIT;
            end else begin
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b1;
              rsp_paddr <= '0;
              rsp_perm  <= PERM_NONE;
              state_q   <= ST_RESP;
            end
          end
        end
        ST_WAIT: begin
          if (mem_rvalid) begin
            rsp_valid <= 1'b1;
            state_q   <= ST_RESP;
            if (mem_rerr) begin
              rsp_fault <= 1'b1;
              rsp_paddr <= '0;
              rsp_perm  <= PERM_NONE;
            end else begin
              rsp_paddr <= {mem_rdata[ADDR_W-1:PAGE_SHIFT], offset_q};
              rsp_perm  <= PERM_RW;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dxw_walker.sv
module dxw_walker #(
  parameter int ADDR_W      = 32,
  parameter int PAGE_SHIFT  = 12,
  parameter int ENTRY_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [ADDR_W-1:0] mem_rdata,
  input  logic              mem_rerr,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [1:0]        rsp_perm,
  output logic              rsp_fault
);
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] limit_q;
  logic              in_range;
  logic [ADDR_W-1:0] slot_addr;

  dxw_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .base_q(base_q), .limit_q(limit_q)
  );

  dxw_index_check #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .ENTRY_SHIFT(ENTRY_SHIFT)
  ) u_chk_idx (
    .addr(req_addr), .base(base_q), .limit(limit_q),
    .in_range(in_range), .slot_addr(slot_addr)
  );

  dxw_seq #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .in_range(in_range), .slot_addr(slot_addr), .req_ready(req_ready),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .mem_rerr(mem_rerr), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm), .rsp_fault(rsp_fault)
  );
endmodule

// File: rtl/dxw_checker.sv
module dxw_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              mem_req,
  input logic              mem_rvalid,
  input logic              rsp_valid,
  input logic              rsp_fault,
  input logic [1:0]        rsp_perm,
  input logic [ADDR_W-1:0] rsp_paddr
);
  AST_FAULT_NEEDS_RSP: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> rsp_valid); // R8
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R8
  AST_MEM_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req); // R4
  AST_BUSY_DURING_FETCH: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready); // R5
  AST_BUSY_DURING_RSP: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready); // R5
  AST_GRANT_RW: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |-> (rsp_perm == 2'b11)); // R6
  AST_GRANT_AFTER_RETURN: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |-> $past(mem_rvalid)); // R6
  AST_FAULT_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_perm == 2'b00 && rsp_paddr == '0)); // R7
endmodule

bind dxw_walker dxw_checker #(.ADDR_W(ADDR_W)) u_dxw_checker (
  .clk(clk), .rst(rst), .req_ready(req_ready), .mem_req(mem_req),
  .mem_rvalid(mem_rvalid), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
  .rsp_perm(rsp_perm), .rsp_paddr(rsp_paddr)
);

// File: tb/dxw_walker_tb.sv
module dxw_walker_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        mem_rerr;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_perm;
  logic        rsp_fault;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // memory model
  int          lat = 1;
  logic [31:0] err_addr = 32'hFFFF_FFF0;
  logic        model_rv = 1'b0;
  logic        stray_rv = 1'b0;
  logic [31:0] model_data = '0;
  logic        model_err = 1'b0;
  logic        pend = 1'b0;
  int          cnt = 0;
  logic [31:0] pend_addr = '0;

  assign mem_rvalid = model_rv | stray_rv;
  assign mem_rdata  = model_data;
  assign mem_rerr   = model_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  dxw_walker u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rerr(mem_rerr),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm),
    .rsp_fault(rsp_fault)
  );

  function automatic logic [31:0] frame_of(input logic [31:0] a);
    return a ^ 32'hC3C3_0ABC;
  endfunction

  always @(posedge clk) begin
    model_rv <= 1'b0;
    if (mem_req) begin
      pend      <= 1'b1;
      cnt       <= lat;
      pend_addr <= mem_addr;
    end else if (pend) begin
      if (cnt > 1) cnt <= cnt - 1;
      else begin
        pend       <= 1'b0;
        model_rv   <= 1'b1;
        model_data <= frame_of(pend_addr);
        model_err  <= (pend_addr == err_addr);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one translation; returns response fields and observations
  task automatic xlate(input logic [31:0] a, output bit got,
                       output logic [31:0] pa, output logic [1:0] pm,
                       output logic flt, output int nreq,
                       output logic [31:0] faddr, output int rdy_hi,
                       output bit pulse_ok);
    got = 0; nreq = 0; faddr = '0; rdy_hi = 0; pulse_ok = 0;
    pa = '0; pm = '0; flt = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 60; k++) begin
      if (mem_req) begin nreq++; faddr = mem_addr; end
      if (rsp_valid) begin
        got = 1; pa = rsp_paddr; pm = rsp_perm; flt = rsp_fault;
        if (req_ready) rdy_hi++;
        break;
      end
      if (req_ready) rdy_hi++;
      @(negedge clk);
    end
    @(negedge clk);
    pulse_ok = !rsp_valid && !rsp_fault;
  endtask

  task automatic t_reset();
    bit g; logic [31:0] pa, fa; logic [1:0] pm; logic fl; int nr, rh; bit po;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 1);
    chk(rsp_valid == 1'b0 && rsp_fault == 1'b0, "R1 rsp idle after reset",
        32'(rsp_valid), 0);
    chk(mem_req == 1'b0, "R1 mem_req idle after reset", 32'(mem_req), 0);
    xlate(32'h0000_0123, g, pa, pm, fl, nr, fa, rh, po);
    chk(g && fl && nr == 0, "R1 zero length faults", 32'(fl), 1);
  endtask

  task automatic t_hit();
    bit g; logic [31:0] pa, fa, e; logic [1:0] pm; logic fl; int nr, rh; bit po;
    cfg_write(1'b0, 32'h8001_0000);
    cfg_write(1'b1, 32'h0000_0040);
    xlate(32'h0000_3ABC, g, pa, pm, fl, nr, fa, rh, po);
    chk(nr == 1, "R4 single fetch pulse", 32'(nr), 1);
    chk(fa == 32'h0001_0018, "R4 slot address bit31 cleared", fa, 32'h0001_0018);
    e = {frame_of(32'h0001_0018) >> 12, 12'hABC};
    chk(g && pa == e, "R6 physical address", pa, e);
    chk(pm == 2'b11 && !fl, "R6 rw grant", 32'(pm), 3);
    chk(po, "R8 response single cycle", 32'(po), 1);
    chk(rh == 0, "R5 ready low while busy", 32'(rh), 0);
  endtask

  task automatic t_bounds();
    bit g; logic [31:0] pa, fa, e; logic [1:0] pm; logic fl; int nr, rh; bit po;
    xlate(32'h0000_7000, g, pa, pm, fl, nr, fa, rh, po);
    e = {frame_of(32'h0001_0038) >> 12, 12'h000};
    chk(g && !fl && pa == e, "R3 last slot in range", pa, e);
    xlate(32'h0000_8FFF, g, pa, pm, fl, nr, fa, rh, po);
    chk(g && fl && nr == 0, "R3 index at limit faults", 32'(nr), 0);
    chk(pa == 0 && pm == 2'b00, "R3 fault result zero", pa, 0);
    chk(rh == 0 && po, "R8 fault pulse single cycle", 32'(rh), 0);
    cfg_write(1'b1, 32'h0000_0047);
    xlate(32'h0000_8000, g, pa, pm, fl, nr, fa, rh, po);
    chk(g && fl && nr == 0, "R3 length floored to slots", 32'(fl), 1);
  endtask

  task automatic t_err();
    bit g; logic [31:0] pa, fa; logic [1:0] pm; logic fl; int nr, rh; bit po;
    err_addr = 32'h0001_0010;
    xlate(32'h0000_2555, g, pa, pm, fl, nr, fa, rh, po);
    chk(g && fl, "R7 read error faults", 32'(fl), 1);
    chk(pa == 0 && pm == 2'b00, "R7 no access on error", pa, 0);
    err_addr = 32'hFFFF_FFF0;
  endtask

  task automatic t_slow_and_rebase();
    bit g; logic [31:0] pa, fa, e; logic [1:0] pm; logic fl; int nr, rh; bit po;
    lat = 6;
    cfg_write(1'b0, 32'h0002_0004);
    xlate(32'h0000_1FFF, g, pa, pm, fl, nr, fa, rh, po);
    chk(fa == 32'h0002_000C, "R2 new base used", fa, 32'h0002_000C);
    chk(rh == 0, "R5 ready low across slow fetch", 32'(rh), 0);
    e = {frame_of(32'h0002_000C) >> 12, 12'hFFF};
    chk(g && pa == e, "R6 slow fetch result", pa, e);
    lat = 1;
  endtask

  task automatic t_stray();
    int seen = 0;
    @(negedge clk); stray_rv = 1'b1;
    @(negedge clk); stray_rv = 1'b0;
    for (int k = 0; k < 5; k++) begin
      if (rsp_valid) seen++;
      @(negedge clk);
    end
    chk(seen == 0, "R9 stray return ignored", 32'(seen), 0);
    chk(req_ready == 1'b1, "R9 still idle", 32'(req_ready), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_hit();
    t_bounds();
    t_err();
    t_slow_and_rebase();
    t_stray();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule